// File: doc/BRIEF.md
# Printer Port Register Block with Emulated Printer Handshake

This block is the host-facing register file of a legacy byte-wide printer port used with no printer attached. The host sees three live registers, for output data, printer status and port control, inside an eight-location window. The block plays the printer's part itself. A strobe pulse written through the control register releases the current output byte on a one-cycle stream port. Later status reads then walk the busy and acknowledge bits through the sequence a real printer would produce. No cable timing is modelled: the handshake moves forward only when the host touches the registers.

A level interrupt is raised when the host drops the strobe while select and init are high and interrupts were already enabled. Any status read clears it. A separate sample strobe loads an input byte latch. The host reads that latch through the data location when the direction bit selects input.

Read data is combinational. It reflects the state before the access, and every side effect of the access takes effect at the closing clock edge.

Top module: `lpt_regs`

## Requirements
- R1: Only the low three address bits are decoded, so addresses alias modulo 8. Location 0 is data, 1 is status and 2 is control. Reads of locations 3 to 7 return 0xFF, and writes to them change no register.
- R2: After reset the output latch and the input latch both hold 0xFF, status is 0xD9, control is 0xCC, the interrupt is low and no byte is emitted.
- R3: A control write stores the written value with bits 7 and 6 forced to 1, and a control read returns the stored value.
- R4: A control write with init (bit 2) at 0 loads status with 0xD8.
- R5: A control write with init (bit 2), select (bit 3) and strobe (bit 0) all at 1 clears status busy (bit 7). If the stored strobe bit was 0 before that write, the block presents the output latch on the byte port with the valid strobe high for exactly the one cycle after the write edge. With a stored strobe of 1, nothing is emitted.
- R6: A control write with init and select at 1 and strobe at 0 sets the interrupt when the previously stored interrupt-enable bit (bit 4) is 1. No other access sets it, and the interrupt output is a level that follows this pending flag.
- R7: A data read returns the input latch when control direction (bit 5) is 1, and the output latch when it is 0.
- R8: A status read returns the status held before the read and clears the interrupt.
- R9: After a status read, if status busy (bit 7) and the stored control strobe (bit 0) are both 0, then acknowledge (bit 6) is cleared when it was 1. When acknowledge was 0, acknowledge and busy are both set.
- R10: The input latch loads the sample input in each cycle where the sample strobe is high.
- R11: A data write stores the byte in the output latch without touching the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | AW | Host register address, low three bits decoded |
| host_wr | input | 1 | Host write strobe for this cycle |
| host_rd | input | 1 | Host read strobe for this cycle (side effects at the edge) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the current address |
| smp_en | input | 1 | Loads the input latch |
| smp_data | input | 8 | Byte for the input latch |
| irq | output | 1 | Level interrupt |
| out_valid | output | 1 | One-cycle valid for an emitted byte |
| out_byte | output | 8 | Emitted byte |

## Verification
The assertions assume that the host never issues a read and a write in the same cycle. They also assume that the address and strobes are stable across the clock edge. The first assumption is itself checked as a property. The bench issues every access from a task that raises exactly one strobe for one cycle and changes inputs only at the falling edge. The sample strobe is raised only between host accesses.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int DW    = 8;
    localparam int OFF_W = 3;

    localparam logic [OFF_W-1:0] OFF_DATA = 3'd0;
    localparam logic [OFF_W-1:0] OFF_STS  = 3'd1;
    localparam logic [OFF_W-1:0] OFF_CTRL = 3'd2;

    // status bit positions
    localparam int ST_BUSY_N = 7;
    localparam int ST_ACK    = 6;
    // control bit positions
    localparam int CT_DIR    = 5;
    localparam int CT_IEN    = 4;
    localparam int CT_SEL    = 3;
    localparam int CT_INIT   = 2;
    localparam int CT_STB    = 0;

    localparam logic [DW-1:0] CTRL_FORCE   = 8'hC0;
    localparam logic [DW-1:0] STS_RESET    = 8'hD9;
    localparam logic [DW-1:0] STS_INITLOAD = 8'hD8;
    localparam logic [DW-1:0] CTRL_RESET   = 8'hCC;
    localparam logic [DW-1:0] IDLE_READ    = 8'hFF;

    typedef struct packed {
        logic [DW-1:0] out_lat;
        logic [DW-1:0] in_lat;
        logic [DW-1:0] sts;
        logic [DW-1:0] ctl;
        logic          pend;
        logic          tx_vld;
        logic [DW-1:0] tx_dat;
    } lpt_state_t;
endpackage

// File: rtl/lpt_addr_dec.sv
module lpt_addr_dec
    import lpt_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic [AW-1:0] addr,
    output logic          sel_data,
    output logic          sel_sts,
    output logic          sel_ctrl
);
    logic [OFF_W-1:0] off;

    generate
        if (AW > OFF_W) begin : g_alias
            logic [AW-OFF_W-1:0] unused_hi;
            assign unused_hi = addr[AW-1:OFF_W];
            assign off       = addr[OFF_W-1:0];
        end else begin : g_exact
            assign off = OFF_W'(addr);
        end
    endgenerate

    always_comb begin
        sel_data = (off == OFF_DATA);
        sel_sts  = (off == OFF_STS);
        sel_ctrl = (off == OFF_CTRL);
    end
endmodule

// File: rtl/lpt_core.sv
module lpt_core
    import lpt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data_en,
    input  logic          wr_ctrl_en,
    input  logic          rd_sts_en,
    input  logic [DW-1:0] wdata,
    input  logic          smp_en,
    input  logic [DW-1:0] smp_data,
    output lpt_state_t    st_q
);
    lpt_state_t    st_d;
    logic [DW-1:0] ctl_new_d;

    always_comb begin
        st_d        = st_q;
        st_d.tx_vld = 1'b0;
        ctl_new_d   = wdata | CTRL_FORCE;

        if (smp_en)
            st_d.in_lat = smp_data;

        if (wr_data_en)
            st_d.out_lat = wdata;

        if (wr_ctrl_en) begin
            if (!ctl_new_d[CT_INIT]) begin
                st_d.sts = STS_INITLOAD;
            end else if (ctl_new_d[CT_SEL]) begin
                if (ctl_new_d[CT_STB]) begin
                    st_d.sts[ST_BUSY_N] = 1'b0;
                    if (!st_q.ctl[CT_STB]) begin
                        st_d.tx_vld = 1'b1;
                        st_d.tx_dat = st_q.out_lat;
                    end
                end else if (st_q.ctl[CT_IEN]) begin
                    st_d.pend = 1'b1;
                end
            end
            st_d.ctl = ctl_new_d;
        end

        if (rd_sts_en) begin
            st_d.pend = 1'b0;
            if (!st_q.sts[ST_BUSY_N] && !st_q.ctl[CT_STB]) begin
                if (st_q.sts[ST_ACK]) begin
                    st_d.sts[ST_ACK] = 1'b0;
                end else begin
                    st_d.sts[ST_ACK]    = 1'b1;
                    st_d.sts[ST_BUSY_N] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.out_lat <= IDLE_READ;
            st_q.in_lat  <= IDLE_READ;
            st_q.sts     <= STS_RESET;
            st_q.ctl     <= CTRL_RESET;
            st_q.pend    <= 1'b0;
            st_q.tx_vld  <= 1'b0;
            st_q.tx_dat  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ACK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sts_en && !st_q.sts[ST_BUSY_N] && !st_q.ctl[CT_STB] && st_q.sts[ST_ACK])
        |=> !st_q.sts[ST_ACK]) else $error("ack step"); // R9
endmodule

// File: rtl/lpt_rd_mux.sv
module lpt_rd_mux
    import lpt_pkg::*;
(
    input  logic          sel_data,
    input  logic          sel_sts,
    input  logic          sel_ctrl,
    input  lpt_state_t    st,
    output logic [DW-1:0] rdata
);
    always_comb begin
        if (sel_data)
            rdata = st.ctl[CT_DIR] ? st.in_lat : st.out_lat;
        else if (sel_sts)
            rdata = st.sts;
        else if (sel_ctrl)
            rdata = st.ctl;
        else
            rdata = IDLE_READ;
    end
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic          smp_en,
    input  logic [7:0]    smp_data,
    output logic          irq,
    output logic          out_valid,
    output logic [7:0]    out_byte
);
    logic       sel_data, sel_sts, sel_ctrl;
    lpt_state_t st;

    lpt_addr_dec #(.AW(AW)) u_dec (
        .addr     (host_addr),
        .sel_data (sel_data),
        .sel_sts  (sel_sts),
        .sel_ctrl (sel_ctrl)
    );

    lpt_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_en (host_wr && sel_data),
        .wr_ctrl_en (host_wr && sel_ctrl),
        .rd_sts_en  (host_rd && sel_sts),
        .wdata      (host_wdata),
        .smp_en     (smp_en),
        .smp_data   (smp_data),
        .st_q       (st)
    );

    lpt_rd_mux u_mux (
        .sel_data (sel_data),
        .sel_sts  (sel_sts),
        .sel_ctrl (sel_ctrl),
        .st       (st),
        .rdata    (host_rdata)
    );

    assign irq       = st.pend;
    assign out_valid = st.tx_vld;
    assign out_byte  = st.tx_dat;

    AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && host_wr)) else $error("read and write together"); // R1
    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !sel_data && !sel_sts && !sel_ctrl)
        |=> ($stable(st.ctl) && $stable(st.sts) && $stable(st.out_lat))) else $error("ignored write"); // R1
    AST_CTRL_HIGH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        st.ctl[7:6] == 2'b11) else $error("ctrl high bits"); // R3
    AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && sel_ctrl && !host_wdata[2]) |=> (st.sts == 8'hD8)) else $error("init load"); // R4
    AST_TX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(host_wr && sel_ctrl && host_wdata[0] && host_wdata[2] && host_wdata[3]))
        else $error("tx cause"); // R5
    AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid) else $error("tx length"); // R5
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(host_wr && sel_ctrl && !host_wdata[0] && st.ctl[4]))
        else $error("irq cause"); // R6
    AST_STS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && sel_sts) |=> !irq) else $error("irq clear"); // R8
endmodule

// File: tb/lpt_regs_tb.sv
module lpt_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] host_addr;
    logic       host_wr, host_rd;
    logic [7:0] host_wdata, host_rdata;
    logic       smp_en;
    logic [7:0] smp_data;
    logic       irq, out_valid;
    logic [7:0] out_byte;

    int checks = 0;
    int failures = 0;
    int tx_count = 0;

    always #4 clk = ~clk;

    lpt_regs #(.AW(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .smp_en(smp_en), .smp_data(smp_data), .irq(irq),
        .out_valid(out_valid), .out_byte(out_byte)
    );

    always @(negedge clk) if (rst_n && out_valid) tx_count++;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // inputs change on the falling edge; the access commits at the next rising edge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 check(tag, host_rdata, exp);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R2 irq", {7'd0, irq}, 8'h00);
        check("R2 out_valid", {7'd0, out_valid}, 8'h00);
        rd(4'd0, 8'hFF, "R2 data reset");
        rd(4'd1, 8'hD9, "R2 status reset");
        rd(4'd2, 8'hCC, "R2 control reset");
    endtask

    task automatic t_decode;
        wr(4'd3, 8'h00);
        rd(4'd3, 8'hFF, "R1 offset 3 read");
        rd(4'd7, 8'hFF, "R1 offset 7 read");
        rd(4'd2, 8'hCC, "R1 ignored write ctrl");
        rd(4'd1, 8'hD9, "R1 ignored write status");
        wr(4'd8, 8'h3C);
        rd(4'd0, 8'h3C, "R1 alias data write / R11");
        rd(4'd10, 8'hCC, "R1 alias ctrl read");
    endtask

    task automatic t_ctrl_force;
        wr(4'd2, 8'h04);
        rd(4'd2, 8'hC4, "R3 forced high bits");
        rd(4'd1, 8'hD9, "R3 no status change");
        wr(4'd2, 8'h0C);
        rd(4'd2, 8'hCC, "R3 restore");
    endtask

    task automatic t_print;
        int base;
        wr(4'd0, 8'h41);
        base = tx_count;
        wr(4'd2, 8'h0D);
        check("R5 out_valid after strobe", {7'd0, out_valid}, 8'h01);
        check("R5 out_byte", out_byte, 8'h41);
        @(negedge clk);
        check("R5 out_valid one cycle", {7'd0, out_valid}, 8'h00);
        wr(4'd2, 8'h0D);
        check("R5 no emit on held strobe", 8'(tx_count - base), 8'd1);
        rd(4'd1, 8'h59, "R5 busy cleared");
        rd(4'd1, 8'h59, "R9 no step while strobe high");
        wr(4'd2, 8'h0C);
        rd(4'd1, 8'h59, "R9 read 1");
        rd(4'd1, 8'h19, "R9 ack cleared");
        rd(4'd1, 8'hD9, "R9 ack and busy set");
        rd(4'd1, 8'hD9, "R9 busy holds");
    endtask

    task automatic t_init;
        wr(4'd2, 8'h08);
        rd(4'd1, 8'hD8, "R4 init low loads status");
        rd(4'd2, 8'hC8, "R4 ctrl stored");
    endtask

    task automatic t_irq;
        wr(4'd2, 8'h1C);
        check("R6 no irq when enable was 0", {7'd0, irq}, 8'h00);
        wr(4'd2, 8'h1C);
        check("R6 irq set", {7'd0, irq}, 8'h01);
        wr(4'd0, 8'h77);
        check("R11 data write keeps irq", {7'd0, irq}, 8'h01);
        rd(4'd1, 8'hD8, "R8 status returned");
        check("R8 irq cleared", {7'd0, irq}, 8'h00);
        wr(4'd2, 8'h14);
        check("R6 select low no irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_dir;
        @(negedge clk);
        smp_data = 8'h5A; smp_en = 1'b1;
        @(negedge clk);
        smp_en = 1'b0; smp_data = 8'h00;
        wr(4'd2, 8'h2C);
        rd(4'd0, 8'h5A, "R10 R7 input latch read");
        wr(4'd2, 8'h0C);
        rd(4'd0, 8'h77, "R7 output latch read");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0x00 expected=0x01");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; host_addr = '0; host_wr = 1'b0; host_rd = 1'b0;
        host_wdata = '0; smp_en = 1'b0; smp_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_ctrl_force();
        t_print();
        t_init();
        t_irq();
        t_dir();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule